// File: doc/BRIEF.md
# Indirect CSR Range Splitter

This block serves a host request to read or write any byte range in the low control/status space of a remote device, the part of the address map below 0x1000. The device exposes that space only through two registers: a 32-bit data register at 0x300 and a command register at 0x304. The block cuts the range into pieces whose size follows the alignment rules of the device. For each piece it issues the data and command register accesses through a register-access engine, which is a separate block that does the serial framing. It then polls the command register until the busy flag clears.

On a write, the block pulls the host's bytes one at a time in order and packs them into the data word. On a read, it unpacks the returned data word and presents the bytes to the host one at a time in order. A request at 0x1000 or above belongs to the process RAM path. The block does not split it: it raises a one-cycle hand-off pulse and stays idle.

Top module: `csr_range_splitter`

## Requirements
- R1: A piece that starts at an odd address is 1 byte long.
- R2: The tentative size of a piece is the smaller of the remaining length and 4. When address bit 1 is set and bit 0 is clear, the piece is 2 bytes if that tentative size is even and 1 byte if it is odd.
- R3: At a 4-byte-aligned address a tentative size of 3 becomes 1, and sizes 1, 2 and 4 are kept. Every command the block issues carries a size of 1, 2 or 4.
- R4: A read piece is served in this order. First, a write to the command register (0x304) with bit 31 and bit 30 set, the size in bits 23:16 and the address in bits 15:0. Next, reads of 0x304 repeated while bit 31 of the returned value is 1. Last, one read of the data register (0x300).
- R5: A write piece is served in this order. First, a write of the data register (0x300). Next, a write of 0x304 with bit 31 set, bit 30 clear, the size in bits 23:16 and the address in bits 15:0. Last, reads of 0x304 repeated while bit 31 is 1.
- R6: Byte i of a piece (i from 0) occupies data-word bits 8i+7:8i. On a write, the lanes above the piece size are zero.
- R7: After each piece, the address advances and the remaining length falls by the piece size. After the last piece, `done` is high for exactly one cycle. A request of length 0 raises `done` with no register access.
- R8: A request with address 0x1000 or above raises `pram_start` for one cycle. It causes no register access and no `done`, and the block stays idle.
- R9: A register request holds `reg_wr`, `reg_addr` and `reg_wdata` steady until the cycle in which `reg_ack` is high.
- R10: A read request produces exactly one `rd_valid` pulse per byte, in address order. A write request produces exactly one `wr_take` pulse per byte, and the byte on `wr_byte` is consumed in the cycle of that pulse.
- R11: A `start` while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | First byte address |
| req_len | input | 16 | Byte count |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse after the last piece |
| pram_start | output | 1 | Hand-off pulse for an address at 0x1000 or above |
| wr_take | output | 1 | The byte on wr_byte is consumed this cycle |
| wr_byte | input | 8 | Next write byte from the host |
| rd_valid | output | 1 | rd_byte holds the next read byte |
| rd_byte | output | 8 | Read byte |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 = register write, 0 = register read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 32 | Register write value |
| reg_ack | input | 1 | Access complete; reg_rdata is valid |
| reg_rdata | input | 32 | Register read value |

## Verification
The hardest case to reach from the ports is the busy-poll loop: the command register must report busy several times in a row while the request line stays high. The bench's register-engine model counts how many polls each command should stay busy, with a count that each scenario sets, and it logs every access so that the whole sequence can be compared. The alignment corners come from start addresses and lengths chosen so that a single request passes through odd, half-word and aligned sizes with 3-byte remainders. This exercises every branch of the size rule within one range.

// File: rtl/csr_split_pkg.sv
package csr_split_pkg;
  localparam int WORD_W       = 32;
  localparam int LANES        = WORD_W / 8;
  localparam int LANE_IDX_W   = $clog2(LANES);
  localparam int SIZE_W       = $clog2(LANES) + 1;
  localparam int CMD_BUSY_BIT = 31;
  localparam int CMD_RD_BIT   = 30;
  localparam int CMD_SIZE_LSB = 16;
  localparam int CMD_SIZE_W   = 8;
  localparam int CMD_ADDR_W   = 16;

  typedef enum logic [3:0] {
    S_IDLE,
    S_GATHER,
    S_PUT_DATA,
    S_PUT_CMD,
    S_POLL,
    S_GET_DATA,
    S_EMIT,
    S_STEP,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/csr_chunk_sizer.sv
module csr_chunk_sizer
  import csr_split_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [SIZE_W-1:0] size
);
  logic [SIZE_W-1:0] tentative;

  always_comb begin
    if (remain > LEN_W'(LANES - 1)) tentative = SIZE_W'(LANES);
    else                            tentative = SIZE_W'(remain);
  end

  always_comb begin
    if (addr[0]) begin
      size = SIZE_W'(1);
    end else if (addr[1]) begin
      size = tentative[0] ? SIZE_W'(1) : SIZE_W'(2);
    end else if (tentative == SIZE_W'(3)) begin
      size = SIZE_W'(1);
    end else begin
      size = tentative;
    end
  end
endmodule

// File: rtl/csr_byte_lanes.sv
module csr_byte_lanes
  import csr_split_pkg::*;
(
  input  logic [WORD_W-1:0]     word_in,
  input  logic [LANE_IDX_W-1:0] lane,
  input  logic [7:0]            byte_in,
  output logic [WORD_W-1:0]     word_ins,
  output logic [7:0]            byte_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_ins[g*8 +: 8] = (lane == LANE_IDX_W'(g)) ? byte_in : word_in[g*8 +: 8];
  end

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LANE_IDX_W'(i)) byte_out = word_in[i*8 +: 8];
    end
  end
endmodule

// File: rtl/csr_split_fsm.sv
module csr_split_fsm
  import csr_split_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              LEN_W     = 16,
  parameter int              REG_AW    = 16,
  parameter logic [15:0]     PRAM_BASE = 16'h1000,
  parameter logic [15:0]     DATA_REG  = 16'h0300,
  parameter logic [15:0]     CMD_REG   = 16'h0304
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  busy,
  output logic                  done,
  output logic                  pram_start,
  output logic                  wr_take,
  input  logic [7:0]            wr_byte,
  output logic                  rd_valid,
  output logic [7:0]            rd_byte,
  output logic                  reg_req,
  output logic                  reg_wr,
  output logic [REG_AW-1:0]     reg_addr,
  output logic [WORD_W-1:0]     reg_wdata,
  input  logic                  reg_ack,
  input  logic [WORD_W-1:0]     reg_rdata,
  output logic [ADDR_W-1:0]     cur_addr,
  output logic [LEN_W-1:0]      cur_remain,
  input  logic [SIZE_W-1:0]     piece_size,
  output logic [WORD_W-1:0]     lane_word,
  output logic [LANE_IDX_W-1:0] lane_sel,
  input  logic [WORD_W-1:0]     lane_word_ins,
  input  logic [7:0]            lane_byte_out
);
  seq_state_t            state_q, state_d;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic [LEN_W-1:0]      rem_q, rem_d;
  logic                  wr_q, wr_d;
  logic [LANE_IDX_W-1:0] k_q, k_d;
  logic [WORD_W-1:0]     data_q, data_d;
  logic                  rdv_q, rdv_d;
  logic [7:0]            rdb_q, rdb_d;
  logic                  ctx_en, data_en, k_en, rdb_en;
  logic                  last_lane;
  logic [WORD_W-1:0]     cmd_word;

  assign cur_addr   = addr_q;
  assign cur_remain = rem_q;
  assign lane_word  = data_q;
  assign lane_sel   = k_q;
  assign last_lane  = ({1'b0, k_q} == (piece_size - SIZE_W'(1)));

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_BUSY_BIT] = 1'b1;
    cmd_word[CMD_RD_BIT]   = ~wr_q;
    cmd_word[CMD_SIZE_LSB +: CMD_SIZE_W] = CMD_SIZE_W'(piece_size);
    cmd_word[CMD_ADDR_W-1:0] = CMD_ADDR_W'(addr_q);
  end

  // next-state process
  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    rem_d      = rem_q;
    wr_d       = wr_q;
    k_d        = k_q;
    data_d     = data_q;
    rdv_d      = 1'b0;
    rdb_d      = rdb_q;
    ctx_en     = 1'b0;
    data_en    = 1'b0;
    k_en       = 1'b0;
    rdb_en     = 1'b0;
    pram_start = 1'b0;
    wr_take    = 1'b0;
    done       = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          if (req_addr >= ADDR_W'(PRAM_BASE)) begin
            pram_start = 1'b1;
          end else begin
            ctx_en  = 1'b1;
            data_en = 1'b1;
            k_en    = 1'b1;
            addr_d  = req_addr;
            rem_d   = req_len;
            wr_d    = req_write;
            k_d     = '0;
            data_d  = '0;
            if (req_len == '0)  state_d = S_DONE;
            else if (req_write) state_d = S_GATHER;
            else                state_d = S_PUT_CMD;
          end
        end
      end
      S_GATHER: begin
        wr_take = 1'b1;
        data_en = 1'b1;
        k_en    = 1'b1;
        data_d  = lane_word_ins;
        k_d     = k_q + LANE_IDX_W'(1);
        if (last_lane) state_d = S_PUT_DATA;
      end
      S_PUT_DATA: begin
        if (reg_ack) state_d = S_PUT_CMD;
      end
      S_PUT_CMD: begin
        if (reg_ack) state_d = S_POLL;
      end
      S_POLL: begin
        if (reg_ack && !reg_rdata[CMD_BUSY_BIT]) state_d = wr_q ? S_STEP : S_GET_DATA;
      end
      S_GET_DATA: begin
        if (reg_ack) begin
          data_en = 1'b1;
          k_en    = 1'b1;
          data_d  = reg_rdata;
          k_d     = '0;
          state_d = S_EMIT;
        end
      end
      S_EMIT: begin
        rdv_d  = 1'b1;
        rdb_en = 1'b1;
        rdb_d  = lane_byte_out;
        k_en   = 1'b1;
        k_d    = k_q + LANE_IDX_W'(1);
        if (last_lane) state_d = S_STEP;
      end
      S_STEP: begin
        ctx_en  = 1'b1;
        data_en = 1'b1;
        k_en    = 1'b1;
        addr_d  = addr_q + ADDR_W'(piece_size);
        rem_d   = rem_q - LEN_W'(piece_size);
        k_d     = '0;
        data_d  = '0;
        if (rem_q == LEN_W'(piece_size)) state_d = S_DONE;
        else if (wr_q)                   state_d = S_GATHER;
        else                             state_d = S_PUT_CMD;
      end
      S_DONE: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      k_q     <= '0;
      data_q  <= '0;
      rdv_q   <= 1'b0;
      rdb_q   <= '0;
    end else begin
      state_q <= state_d;
      rdv_q   <= rdv_d;
      if (ctx_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        wr_q   <= wr_d;
      end
      if (data_en) data_q <= data_d;
      if (k_en)    k_q    <= k_d;
      if (rdb_en)  rdb_q  <= rdb_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign rd_valid = rdv_q;
  assign rd_byte  = rdb_q;

  always_comb begin
    reg_req   = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = REG_AW'(CMD_REG);
    reg_wdata = '0;
    unique case (state_q)
      S_PUT_DATA: begin
        reg_req   = 1'b1;
        reg_wr    = 1'b1;
        reg_addr  = REG_AW'(DATA_REG);
        reg_wdata = data_q;
      end
      S_PUT_CMD: begin
        reg_req   = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = cmd_word;
      end
      S_POLL: begin
        reg_req = 1'b1;
      end
      S_GET_DATA: begin
        reg_req  = 1'b1;
        reg_addr = REG_AW'(DATA_REG);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/csr_range_splitter.sv
module csr_range_splitter
  import csr_split_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          LEN_W     = 16,
  parameter int          REG_AW    = 16,
  parameter logic [15:0] PRAM_BASE = 16'h1000,
  parameter logic [15:0] DATA_REG  = 16'h0300,
  parameter logic [15:0] CMD_REG   = 16'h0304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              pram_start,
  output logic              wr_take,
  input  logic [7:0]        wr_byte,
  output logic              rd_valid,
  output logic [7:0]        rd_byte,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [WORD_W-1:0] reg_rdata
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [ADDR_W-1:0]     cur_addr;
  logic [LEN_W-1:0]      cur_remain;
  logic [SIZE_W-1:0]     piece_size;
  logic [WORD_W-1:0]     lane_word, lane_word_ins;
  logic [LANE_IDX_W-1:0] lane_sel;
  logic [7:0]            lane_byte_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  csr_chunk_sizer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_sizer (
    .addr   (cur_addr),
    .remain (cur_remain),
    .size   (piece_size)
  );

  csr_byte_lanes u_lanes (
    .word_in  (lane_word),
    .lane     (lane_sel),
    .byte_in  (wr_byte),
    .word_ins (lane_word_ins),
    .byte_out (lane_byte_out)
  );

  csr_split_fsm #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW),
    .PRAM_BASE(PRAM_BASE), .DATA_REG(DATA_REG), .CMD_REG(CMD_REG)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start         (start),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .busy          (busy),
    .done          (done),
    .pram_start    (pram_start),
    .wr_take       (wr_take),
    .wr_byte       (wr_byte),
    .rd_valid      (rd_valid),
    .rd_byte       (rd_byte),
    .reg_req       (reg_req),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_ack       (reg_ack),
    .reg_rdata     (reg_rdata),
    .cur_addr      (cur_addr),
    .cur_remain    (cur_remain),
    .piece_size    (piece_size),
    .lane_word     (lane_word),
    .lane_sel      (lane_sel),
    .lane_word_ins (lane_word_ins),
    .lane_byte_out (lane_byte_out)
  );
endmodule

// File: rtl/csr_range_splitter_chk.sv
module csr_range_splitter_chk #(
  parameter int          REG_AW  = 16,
  parameter logic [15:0] CMD_REG = 16'h0304
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pram_start,
  input logic              wr_take,
  input logic              rd_valid,
  input logic              reg_req,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              reg_ack
);
  logic       cmd_wr;
  logic [7:0] cmd_size;
  assign cmd_wr   = reg_req && reg_wr && (reg_addr == REG_AW'(CMD_REG));
  assign cmd_size = reg_wdata[23:16];

  AST_ODD_ADDR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata[0] |-> cmd_size == 8'd1); // R1
  AST_HALF_ADDR_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (reg_wdata[1:0] == 2'b10) |-> (cmd_size == 8'd1) || (cmd_size == 8'd2)); // R2
  AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_size == 8'd1) || (cmd_size == 8'd2) || (cmd_size == 8'd4)); // R3
  AST_CMD_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> reg_wdata[31]); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_PRAM_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pram_start |=> !busy); // R8
  AST_CMD_LOW_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> reg_wdata[15:0] < 16'h1000); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_wr) && $stable(reg_addr) && $stable(reg_wdata)); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req && !wr_take); // R10
endmodule

bind csr_range_splitter csr_range_splitter_chk #(.REG_AW(REG_AW), .CMD_REG(CMD_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .pram_start (pram_start),
  .wr_take    (wr_take),
  .rd_valid   (rd_valid),
  .reg_req    (reg_req),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_ack    (reg_ack)
);

// File: tb/csr_range_splitter_bench.sv
module csr_range_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        busy, done, pram_start, wr_take, rd_valid;
  logic [7:0]  wr_byte, rd_byte;
  logic        reg_req, reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_ack = 1'b0;
  logic [31:0] reg_rdata = '0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  csr_range_splitter u_csr_range_splitter (
    .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .pram_start(pram_start), .wr_take(wr_take), .wr_byte(wr_byte),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  // device model and host model state
  logic [7:0]  mem [256];
  logic [7:0]  wbuf [32];
  logic [7:0]  rbuf [32];
  int          widx = 0, ridx = 0, take_prev = 0;
  int          done_cnt = 0, pram_cnt = 0;
  logic        log_wr [64];
  logic [15:0] log_a [64];
  logic [31:0] log_d [64];
  int          log_n = 0;
  logic [31:0] data_reg = '0, cmd_reg = '0;
  int          busy_left = 0, polls_cfg = 0, dly = 0;

  assign wr_byte = (widx < 32) ? wbuf[widx] : 8'h00;

  always @(negedge clk) begin
    cycles++;
    if (take_prev != 0) widx++;
    take_prev = wr_take ? 1 : 0;
    if (rd_valid) begin
      if (ridx < 32) rbuf[ridx] = rd_byte;
      ridx++;
    end
    if (done) done_cnt++;
    if (pram_start) pram_cnt++;
    if (reg_ack) begin
      reg_ack = 1'b0;
    end else if (reg_req) begin
      if (dly < 1) dly++;
      else begin
        dly = 0;
        if (log_n < 64) begin
          log_wr[log_n] = reg_wr; log_a[log_n] = reg_addr; log_d[log_n] = reg_wdata;
        end
        log_n++;
        if (reg_wr) begin
          if (reg_addr == 16'h0300) data_reg = reg_wdata;
          else if (reg_addr == 16'h0304) begin
            cmd_reg = reg_wdata;
            busy_left = polls_cfg;
            if (reg_wdata[30]) begin
              data_reg = '0;
              for (int i = 0; i < int'(reg_wdata[23:16]); i++)
                data_reg[i*8 +: 8] = mem[8'(reg_wdata[7:0] + 8'(i))];
            end else begin
              for (int i = 0; i < int'(reg_wdata[23:16]); i++)
                mem[8'(reg_wdata[7:0] + 8'(i))] = data_reg[i*8 +: 8];
            end
          end
        end else begin
          if (reg_addr == 16'h0304) begin
            reg_rdata = {(busy_left > 0), cmd_reg[30:0]};
            if (busy_left > 0) busy_left--;
          end else reg_rdata = data_reg;
        end
        reg_ack = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // piece size from R1..R3
  function automatic int piece(input int a, input int r);
    int t;
    t = (r > 4) ? 4 : r;
    if (a % 2 == 1) return 1;
    if ((a / 2) % 2 == 1) return (t % 2 == 1) ? 1 : 2;
    if (t == 3) return 1;
    return t;
  endfunction

  task automatic clear_logs();
    log_n = 0; widx = 0; ridx = 0; take_prev = 0; done_cnt = 0; pram_cnt = 0;
  endtask

  task automatic issue(input bit w, input int a, input int len);
    @(negedge clk);
    start = 1'b1; req_write = w; req_addr = 16'(a); req_len = 16'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // compares the register log with the expected sequence for (w,a,len)
  task automatic check_sequence(input bit w, input int a, input int len, input string tag);
    int e = 0, aa = a, rr = len, s, off = 0, mism = 0;
    logic [31:0] word, cmdw;
    while (rr > 0) begin
      s = piece(aa, rr);
      cmdw = {1'b1, ~w, 6'b0, 8'(s), 16'(aa)};
      if (w) begin
        word = '0;
        for (int i = 0; i < s; i++) word[i*8 +: 8] = wbuf[off + i];
        if (e >= log_n || !log_wr[e] || log_a[e] != 16'h0300 || log_d[e] != word) begin
          mism++; check(0, {tag, " R5 R6 data write"}, (e < log_n) ? log_d[e] : 0, word);
        end
        e++;
      end
      if (e >= log_n || !log_wr[e] || log_a[e] != 16'h0304 || log_d[e] != cmdw) begin
        mism++; check(0, {tag, " R4 R5 command word"}, (e < log_n) ? log_d[e] : 0, cmdw);
      end
      e++;
      for (int p = 0; p <= polls_cfg; p++) begin
        if (e >= log_n || log_wr[e] || log_a[e] != 16'h0304) begin
          mism++; check(0, {tag, " R4 R5 poll read"}, e, p);
        end
        e++;
      end
      if (!w) begin
        if (e >= log_n || log_wr[e] || log_a[e] != 16'h0300) begin
          mism++; check(0, {tag, " R4 data read"}, e, 0);
        end
        e++;
      end
      aa += s; rr -= s; off += s;
    end
    check(log_n == e, {tag, " R7 access count"}, log_n, e);
    check(done_cnt == 1, {tag, " R7 one done pulse"}, done_cnt, 1);
    if (mism == 0) check(1, tag, 0, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !reg_req && !wr_take && !rd_valid && !pram_start,
          "R7 reset idle", {busy, done, reg_req, wr_take, rd_valid, pram_start}, 0);
  endtask

  task automatic t_read(input int a, input int len, input int polls, input string tag);
    int bad = 0;
    clear_logs(); polls_cfg = polls;
    issue(1'b0, a, len); wait_done();
    check_sequence(1'b0, a, len, tag);
    check(ridx == len, {tag, " R10 read byte count"}, ridx, len);
    for (int i = 0; i < len; i++)
      if (rbuf[i] != mem[8'(a + i)]) begin
        bad++; check(0, {tag, " R6 R10 read byte order"}, rbuf[i], mem[8'(a + i)]);
      end
    if (bad == 0) check(1, tag, 0, 0);
  endtask

  task automatic t_write(input int a, input int len, input int polls, input string tag);
    int bad = 0;
    clear_logs(); polls_cfg = polls;
    for (int i = 0; i < 32; i++) wbuf[i] = 8'(8'hA0 + i * 7);
    issue(1'b1, a, len); wait_done();
    check_sequence(1'b1, a, len, tag);
    check(widx == len, {tag, " R10 write byte count"}, widx, len);
    for (int i = 0; i < len; i++)
      if (mem[8'(a + i)] != wbuf[i]) begin
        bad++; check(0, {tag, " R10 written byte"}, mem[8'(a + i)], wbuf[i]);
      end
    check(mem[8'(a + len)] == 8'(8'h5A ^ 8'(a + len)), {tag, " R6 neighbour untouched"},
          mem[8'(a + len)], 8'(8'h5A ^ 8'(a + len)));
  endtask

  task automatic t_zero_len();
    clear_logs();
    issue(1'b0, 16'h0040, 0); repeat (4) @(negedge clk);
    check(done_cnt == 1, "R7 zero length done", done_cnt, 1);
    check(log_n == 0 && ridx == 0, "R7 zero length no access", log_n, 0);
  endtask

  task automatic t_pram();
    clear_logs();
    issue(1'b1, 16'h1000, 8); repeat (10) @(negedge clk);
    check(pram_cnt == 1, "R8 hand-off pulse", pram_cnt, 1);
    check(log_n == 0 && done_cnt == 0 && widx == 0, "R8 no access no done", log_n + done_cnt, 0);
    check(!busy, "R8 stays idle", busy, 0);
  endtask

  task automatic t_busy_start();
    clear_logs(); polls_cfg = 1;
    issue(1'b0, 16'h0009, 5);
    repeat (3) @(negedge clk);
    start = 1'b1; req_write = 1'b1; req_addr = 16'h0080; req_len = 16'd4;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);
    check(widx == 0, "R11 busy start took no bytes", widx, 0);
    check_sequence(1'b0, 16'h0009, 5, "R11 busy start ignored");
    check(!busy, "R11 idle after", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(8'h5A ^ i);
    for (int i = 0; i < 32; i++) begin wbuf[i] = '0; rbuf[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read(16'h0000, 4, 0, "R3 aligned word read");
    t_read(16'h0001, 7, 2, "R1 R2 mixed read");
    t_read(16'h0004, 3, 1, "R3 aligned three read");
    t_read(16'h0006, 6, 0, "R2 half then word read");
    t_write(16'h0010, 3, 1, "R3 aligned three write");
    t_write(16'h0022, 3, 0, "R2 odd tentative write");
    t_write(16'h0026, 6, 2, "R2 R6 half word write");
    t_write(16'h0031, 9, 0, "R1 long write");
    t_zero_len();
    t_pram();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule